// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a slave on a two-wire, open-drain serial bus that fronts a byte-wide storage array and behaves like a serial EEPROM. It oversamples SCL and SDA with the system clock, recognises start and stop conditions, and compares a 7-bit device address against a fixed 4-bit type code followed by three strap inputs. Up to eight such slaves can therefore share one bus. A master writes a two-byte word address and then either data bytes for a byte or page write, or a repeated start and a read-mode device address for a random read. Reads continue sequentially while the master keeps acknowledging.

A stop that ends a write carrying data starts an emulated self-timed write cycle. For a parameterised number of system clocks the slave ignores the bus entirely, so a master can poll for completion by sending its address until it is acknowledged. A write-protect input keeps the array from being changed. The slave never drives SDA high. It only pulls the line low through `sda_oe`, and the bus resistor provides the high level.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset the slave is idle and does not pull SDA low (`sda_oe` = 0).
- R2: The device byte is {type code 4'b1010, strap_a[2:0], R/W}, most significant bit first, with R/W = 1 meaning read. On a match the slave pulls SDA low during the ninth SCL clock. On any mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: In write mode the next two bytes form the word address, high byte first. Each is acknowledged. Address bits above the array width are ignored.
- R4: Each data byte after the word address is acknowledged and stored at the address pointer. The pointer's low log2(PAGE_BYTES) bits then increment modulo the page size, and its upper bits stay fixed. The page size and the array size are powers of two.
- R5: A stop that follows at least one stored data byte starts a busy window of WR_CYCLES clocks. During that window no start, address or data is acknowledged. Once the window ends, an address is acknowledged again.
- R6: While `wp` is 1, data bytes are still acknowledged but the array keeps its contents, and the following stop starts no busy window.
- R7: Random read works as follows. The master sends a write-mode device byte and the word address, then a repeated start and a read-mode device byte. After acknowledging, the slave shifts out the byte at that address, MSB first, changing SDA only while SCL is low.
- R8: In a read, each master acknowledge (SDA low in the ninth clock) advances the pointer by one, wrapping at the array end, and the next byte is sent. A no-acknowledge followed by a stop ends the read with SDA released.
- R9: A read-mode device byte sent without a new word address reads from the pointer left by the previous access. After a write, that is the page-wrapped byte following the last one written. After a read, it is the byte after the last one sent.
- R10: A write transfer stopped before any data byte (an address-only or polling transfer) starts no busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a | input | 3 | Device-select straps compared with device-byte bits 3..1 |
| wp | input | 1 | Write protect, 1 blocks array updates |

## Verification
A corrupted address pointer shows as a wrong data byte on the very next read, whether that read is current-address, random or sequential. Checking reads straddling the page edge and the array end therefore exposes bad wrap logic within one byte. A bit counter or state that falls out of step moves the acknowledge by a clock, and the master sees it at the ninth bit of the same byte. A busy window that is too long, too short or started at the wrong time shows in the acknowledge of the first or second polling address after a stop.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int          MEM_BYTES  = 1024,
  parameter int          PAGE_BYTES = 64,
  parameter int          WR_CYCLES  = 1000,
  parameter logic [3:0]  DEV_TYPE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_a,
  input  logic       wp
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_t;

  logic          scl_q, scl_d, sda_q, sda_d;
  st_t           st;
  kind_t         kind;
  logic [3:0]    cnt;
  logic [7:0]    sh, hi_q;
  logic [AW-1:0] ptr;
  logic          rd_mode, m_nack, dirty;
  logic [CW-1:0] busy_cnt;
  logic [7:0]    mem [MEM_BYTES];

  logic start_ev, stop_ev, rise, fall, busy, dev_hit, byte_done, mem_we, st_idle;
  logic [AW-1:0] ptr_pg;

  assign start_ev  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev   = scl_q & scl_d & ~sda_d & sda_q;
  assign rise      = scl_q & ~scl_d;
  assign fall      = ~scl_q & scl_d;
  assign busy      = |busy_cnt;
  assign dev_hit   = sh[7:1] == {DEV_TYPE, strap_a};
  assign byte_done = (st == S_RX) && fall && (cnt == 4'd8);
  assign mem_we    = byte_done && (kind == K_DATA) && !wp;
  assign ptr_pg    = {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
  assign st_idle   = st == S_IDLE;
  assign sda_oe    = (st == S_RXACK) | ((st == S_TX) & ~sh[7]);

  always_ff @(posedge clk)
    if (mem_we) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_d <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
      st <= S_IDLE; kind <= K_DEV; cnt <= '0; sh <= '0; hi_q <= '0;
      ptr <= '0; rd_mode <= 1'b0; m_nack <= 1'b1; dirty <= 1'b0;
      busy_cnt <= '0;
    end else begin
      scl_q <= scl_i; scl_d <= scl_q;
      sda_q <= sda_i; sda_d <= sda_q;
      if (busy) begin
        busy_cnt <= busy_cnt - CW'(1);
        st <= S_IDLE;
      end else if (start_ev) begin
        st <= S_RX; kind <= K_DEV; cnt <= '0;
      end else if (stop_ev) begin
        st <= S_IDLE; dirty <= 1'b0;
        if (dirty) busy_cnt <= CW'(WR_CYCLES);
      end else begin
        case (st)
          S_RX:
            if (rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              st <= S_RXACK;
              case (kind)
                K_DEV: begin
                  rd_mode <= sh[0];
                  if (!dev_hit) st <= S_IDLE;
                end
                K_AHI: hi_q <= sh;
                K_ALO: ptr <= AW'({hi_q, sh});
                default: begin
                  ptr <= ptr_pg;
                  if (!wp) dirty <= 1'b1;
                end
              endcase
            end
          S_RXACK:
            if (fall) begin
              if (kind == K_DEV && rd_mode) begin
                st <= S_TX; sh <= mem[ptr];
              end else begin
                st <= S_RX;
                case (kind)
                  K_DEV:   kind <= K_AHI;
                  K_AHI:   kind <= K_ALO;
                  default: kind <= K_DATA;
                endcase
              end
            end
          S_TX:
            if (fall) begin
              if (cnt == 4'd7) begin
                st <= S_TXACK; cnt <= '0; ptr <= ptr + AW'(1);
              end else begin
                sh <= {sh[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          S_TXACK:
            if (rise) m_nack <= sda_q;
            else if (fall) begin
              if (!m_nack) begin
                st <= S_TX; sh <= mem[ptr];
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_eeprom_chk.sv
module twowire_eeprom_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          sda_oe,
  input logic [CW-1:0] busy_cnt,
  input logic          stop_ev,
  input logic          st_idle,
  input logic          wp,
  input logic          dirty
);
  logic busy;
  assign busy = |busy_cnt;

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R5
  AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy_cnt == $past(busy_cnt) - CW'(1))); // R5
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev)); // R10
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> st_idle); // R8
  AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q); // R7
  AST_WP_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && $past(wp) && !$past(dirty)) |-> !dirty); // R6
endmodule

bind twowire_eeprom twowire_eeprom_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .busy_cnt(busy_cnt), .stop_ev(stop_ev), .st_idle(st_idle),
  .wp(wp), .dirty(dirty)
);

// File: tb/tb_twowire_eeprom.sv
`timescale 1ns/1ps
module tb_twowire_eeprom;
  localparam int MB  = 512;
  localparam int PB  = 8;
  localparam int WRC = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1, wp = 1'b0;
  logic [2:0] strap = STRAP;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = msda & ~sda_oe;

  always #2.5 clk = ~clk;

  twowire_eeprom #(.MEM_BYTES(MB), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_a(strap), .wp(wp));

  int checks = 0, errors = 0, cur = 0;
  bit done = 0;
  logic [7:0] model [MB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; tick(4); scl = 1'b1; tick(4); msda = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(4); scl = 1'b1; tick(4); msda = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
    end
    msda = 1'b1; tick(4); scl = 1'b1; tick(4); ack = !sda_bus; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4); scl = 1'b1; tick(4); d[i] = sda_bus; tick(4); scl = 1'b0;
    end
    tick(2); msda = give_ack ? 1'b0 : 1'b1; tick(4);
    scl = 1'b1; tick(8); scl = 1'b0; tick(1); msda = 1'b1; tick(3);
  endtask

  task automatic page_write(input logic [7:0] hi, input logic [7:0] lo, input int n, input int seed);
    bit a; int base, off, pg, ad; logic [7:0] d;
    base = {hi, lo} & (MB - 1); off = base % PB; pg = base - off;
    bus_start();
    send_byte(DEVW, a); chk(a, "R2 write address ack", a, 1);
    send_byte(hi, a);   chk(a, "R3 high address ack", a, 1);
    send_byte(lo, a);   chk(a, "R3 low address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      ad = pg + (off + i) % PB;
      d = 8'(ad * 29 + seed);
      send_byte(d, a);
      chk(a, wp ? "R6 data ack under protect" : "R4 data ack", a, 1);
      if (!wp) model[ad] = d;
    end
    bus_stop();
    cur = pg + (off + n) % PB;
  endtask

  task automatic poll(output bit ack);
    bus_start(); send_byte(DEVW, ack); bus_stop();
  endtask

  task automatic rd_check(input bit random, input int addr, input int n, input string req);
    bit a; logic [7:0] d; int ea;
    bus_start();
    if (random) begin
      send_byte(DEVW, a); send_byte(8'(addr >> 8), a); send_byte(8'(addr), a);
      bus_start();
    end
    send_byte(DEVR, a); chk(a, "R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      ea = (addr + i) % MB;
      recv_byte(i < n - 1, d);
      chk(d == model[ea], req, d, model[ea]);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R8 SDA released after stop", sda_oe, 0);
    cur = (addr + n) % MB;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a; int polls, nacks;
    tick(10);
    chk(sda_oe == 1'b0, "R1 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1; tick(10);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    // R2: sweep strap field and type code
    for (int s = 0; s < 8; s++) begin
      bus_start(); send_byte({4'b1010, 3'(s), 1'b0}, a); bus_stop();
      chk(a == (s == STRAP), "R2 strap match", a, s == STRAP);
    end
    for (int t = 0; t < 16; t++) begin
      bus_start(); send_byte({4'(t), STRAP, 1'b1}, a); bus_stop();
      chk(a == (t == 10), "R2 type code match", a, t == 10);
    end

    // R10: address-only write leaves slave ready
    bus_start(); send_byte(DEVW, a); send_byte(8'h00, a); send_byte(8'h10, a); bus_stop();
    poll(a); chk(a, "R10 no busy after address-only write", a, 1);

    page_write(8'h00, 8'h00, 8, 3);
    polls = 0; do begin poll(a); polls++; end while (!a && polls < 20);
    page_write(8'h01, 8'hF8, 8, 11);
    polls = 0; do begin poll(a); polls++; end while (!a && polls < 20);

    // R3 upper bits ignored, R4 page wrap with overwrite
    page_write(8'hFF, 8'h23, 10, 57);
    nacks = 0; polls = 0;
    do begin poll(a); polls++; if (!a) nacks++; end while (!a && polls < 20);
    chk(nacks >= 1, "R5 busy nacks polling", nacks, 1);
    chk(a && polls <= 4, "R5 ack returns after busy", polls, 4);

    chk(cur == 9'h125, "R4 pointer wrapped in page", cur, 9'h125);
    rd_check(1'b0, cur, 1, "R9 current read after page write");
    for (int i = 0; i < PB; i++)
      rd_check(1'b1, 9'h120 + i, 1, "R7 random read of page byte");

    rd_check(1'b1, 9'h1FC, 8, "R8 sequential read across array end");
    rd_check(1'b0, cur, 2, "R9 current read after sequential read");

    // R6 write protect
    wp = 1'b1;
    page_write(8'h00, 8'h02, 3, 90);
    poll(a); chk(a, "R6 no busy window under protect", a, 1);
    wp = 1'b0;
    rd_check(1'b1, 0, PB, "R6 array unchanged under protect");

    // R5 upper bound on busy window, R4 single byte write
    page_write(8'h00, 8'h77, 1, 201);
    tick(WRC + 20);
    poll(a); chk(a, "R5 ack after WR_CYCLES", a, 1);
    rd_check(1'b1, 9'h077, 1, "R4 byte write stored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule